// File: doc/BRIEF.md
# DMA Protected-Window Address Checker

This block sits on the upstream request path to system memory, after the IOMMU has already translated the address. Each request carries an address, a kind tag and a transaction tag. The checker decides whether the request may go to DRAM. It raises a fault if the request lands in a protected window that device traffic must never reach. It also flags requests that hit the fixed legacy video hole. The window ends just below a system-management segment base. It extends downward by a programmable number of 1 MiB units.

The window applies only to device DMA and graphics-aperture traffic, and it ignores every other range check. A request in the window is faulted even if translation succeeded. Processor-originated requests are never faulted.

Software can grow or shrink the window while traffic is flowing. A new base and size are first written into a shadow copy. A separate commit strobe then moves both into the active decode on one clock edge. Each request is therefore decoded entirely with the old setting or entirely with the new one, and nothing needs to be flushed.

Top module: `dpr_checker`

## Requirements
- R1: A request sampled with `req_valid` high yields `rsp_valid` high exactly one cycle later, with `rsp_addr`, `rsp_kind` and `rsp_tag` equal to the request's values. `rsp_valid` and all three flags are low in any cycle after a cycle without a request.
- R2: `req_kind` encoding: 0 = processor, 1 = device DMA, 2 = graphics-aperture translated, 3 = other, which is checked like DMA. A processor request never raises `rsp_fault` and never raises `rsp_dram`.
- R3: A checked request with active size nonzero and (base − size·1 MiB) ≤ addr < base raises `rsp_fault` and not `rsp_dram`.
- R4: A checked request with addr < (base − size·1 MiB) and outside the video hole raises `rsp_dram` and not `rsp_fault`.
- R5: Any request with 0xA0000 ≤ addr ≤ 0xBFFFF raises `rsp_vga`, whatever its kind, and never raises `rsp_dram`.
- R6: A request with addr ≥ base raises neither `rsp_dram` nor `rsp_fault`.
- R7: An active size of zero disables the window. No request faults, and checked requests below base and outside the hole go to DRAM.
- R8: If size·1 MiB ≥ base, the window's lower edge is clamped to address 0, so every checked request below base faults.
- R9: `cfg_wr` captures `cfg_base_in` and `cfg_size_in` into a shadow copy only. The decode of later requests does not change until a commit.
- R10: On a `cfg_commit` edge, base and size become active together. A request sampled on that same edge uses the old pair, and a request on the next edge uses the new pair. With `cfg_wr` and `cfg_commit` together, the commit takes the shadow value held before that edge.
- R11: After reset, `rsp_valid` is low and the active base and size are both zero, so no request raises `rsp_dram` or `rsp_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Capture base and size into the shadow copy |
| cfg_base_in | input | ADDR_W | Segment base for the shadow copy |
| cfg_size_in | input | SIZE_W | Window size in 1 MiB units for the shadow copy |
| cfg_commit | input | 1 | Move the shadow copy into the active decode |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Post-translation request address |
| req_kind | input | 2 | Request kind (see R2) |
| req_tag | input | TAG_W | Transaction tag passed through |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_addr | output | ADDR_W | Echoed address |
| rsp_kind | output | 2 | Echoed kind |
| rsp_tag | output | TAG_W | Echoed tag |
| rsp_dram | output | 1 | Request routes to DRAM |
| rsp_fault | output | 1 | Request hit the protected window |
| rsp_vga | output | 1 | Request hit the legacy video hole |

## Verification
The assertions assume reset is held for at least one edge. They also assume `req_kind` is always one of its four codes, so that the processor-exemption and flag-exclusion checks are meaningful. The bench keeps every programmed base at or below the top of the address space and uses sizes that both fit inside the base and exceed it. It drives commits and requests on the same edge and on adjacent edges, so both sides of the switchover are covered without ever leaving `cfg_commit` high across reset.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic [1:0] {
    KIND_CPU   = 2'd0,
    KIND_DMA   = 2'd1,
    KIND_GFX   = 2'd2,
    KIND_OTHER = 2'd3
  } req_kind_e;

  // size unit is one MiB
  localparam int unsigned UNIT_SHIFT = 20;

  // legacy video hole, inclusive low, exclusive high
  localparam logic [63:0] HOLE_LO = 64'h0000_0000_000A_0000;
  localparam logic [63:0] HOLE_HI = 64'h0000_0000_000C_0000;

  function automatic logic kind_is_checked(input logic [1:0] k);
    return req_kind_e'(k) != KIND_CPU;
  endfunction

endpackage

// File: rtl/dpr_range_cmp.sv
module dpr_range_cmp #(
  parameter int unsigned W = 36
) (
  input  logic [W-1:0] addr,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi_excl,
  output logic         hit
);
  always_comb hit = (addr >= lo) && (addr < hi_excl);
endmodule

// File: rtl/dpr_cfg_bank.sv
module dpr_cfg_bank
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 36,
  parameter int unsigned SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_base_in,
  input  logic [SIZE_W-1:0] cfg_size_in,
  input  logic              cfg_commit,
  output logic [ADDR_W-1:0] act_base,
  output logic [ADDR_W-1:0] act_lo,
  output logic              act_en
);
  localparam int unsigned SPAN_W = SIZE_W + UNIT_SHIFT;
  localparam int unsigned WIDE_W = ((SPAN_W > ADDR_W) ? SPAN_W : ADDR_W) + 1;

  logic [ADDR_W-1:0] sh_base;
  logic [SIZE_W-1:0] sh_size;
  logic [WIDE_W-1:0] span_w;
  logic [WIDE_W-1:0] base_w;
  logic [ADDR_W-1:0] lo_next;

  // shadow copy, touched only by cfg_wr
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_base <= '0;
      sh_size <= '0;
    end else if (cfg_wr) begin
      sh_base <= cfg_base_in;
      sh_size <= cfg_size_in;
    end
  end

  // lower edge of the window precomputed off the request path, clamped at 0
  always_comb begin
    span_w = WIDE_W'(sh_size) << UNIT_SHIFT;
    base_w = WIDE_W'(sh_base);
    if (span_w >= base_w) lo_next = '0;
    else                  lo_next = sh_base - span_w[ADDR_W-1:0];
  end

  // active decode, swapped in as a whole on one edge
  always_ff @(posedge clk) begin
    if (rst) begin
      act_base <= '0;
      act_lo   <= '0;
      act_en   <= 1'b0;
    end else if (cfg_commit) begin
      act_base <= sh_base;
      act_lo   <= (sh_size == '0) ? sh_base : lo_next;
      act_en   <= (sh_size != '0);
    end
  end

  // R10: active pair changes only after a commit
  assert_active_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cfg_commit)) |->
      ($stable(act_base) && $stable(act_lo) && $stable(act_en)));

  // R8: the lower edge never passes the base
  assert_lo_not_above_base_R8: assert property (@(posedge clk) disable iff (rst)
    act_lo <= act_base);

  // R7: a disabled window has zero width
  assert_disabled_empty_R7: assert property (@(posedge clk) disable iff (rst)
    !act_en |-> (act_lo == act_base));

endmodule

// File: rtl/dpr_req_decode.sv
module dpr_req_decode
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 36,
  parameter int unsigned TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] act_base,
  input  logic [ADDR_W-1:0] act_lo,
  input  logic              act_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [1:0]        rsp_kind,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic              rsp_dram,
  output logic              rsp_fault,
  output logic              rsp_vga
);
  localparam logic [ADDR_W-1:0] HOLE_LO_A = ADDR_W'(HOLE_LO);
  localparam logic [ADDR_W-1:0] HOLE_HI_A = ADDR_W'(HOLE_HI);

  logic in_win, in_hole, below_lo, checked;
  logic dram_n, fault_n;

  dpr_range_cmp #(.W(ADDR_W)) u_win (
    .addr(req_addr), .lo(act_lo), .hi_excl(act_base), .hit(in_win));

  dpr_range_cmp #(.W(ADDR_W)) u_hole (
    .addr(req_addr), .lo(HOLE_LO_A), .hi_excl(HOLE_HI_A), .hit(in_hole));

  always_comb begin
    checked  = kind_is_checked(req_kind);
    below_lo = req_addr < act_lo;
    fault_n  = checked && act_en && in_win;
    dram_n   = checked && below_lo && !in_hole;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_dram  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_vga   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_dram  <= req_valid && dram_n;
      rsp_fault <= req_valid && fault_n;
      rsp_vga   <= req_valid && in_hole;
    end
  end

  // payload registers carry no reset
  always_ff @(posedge clk) begin
    if (req_valid) begin
      rsp_addr <= req_addr;
      rsp_kind <= req_kind;
      rsp_tag  <= req_tag;
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(rsp_valid || rsp_dram || rsp_fault || rsp_vga));

  assert_cpu_exempt_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == 2'd0) |-> !(rsp_fault || rsp_dram));

  assert_fault_not_dram_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> !rsp_dram);

  assert_hole_not_dram_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_vga |-> !rsp_dram);

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 36,
  parameter int unsigned SIZE_W = 12,
  parameter int unsigned TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_base_in,
  input  logic [SIZE_W-1:0] cfg_size_in,
  input  logic              cfg_commit,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [1:0]        rsp_kind,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic              rsp_dram,
  output logic              rsp_fault,
  output logic              rsp_vga
);
  logic [ADDR_W-1:0] act_base;
  logic [ADDR_W-1:0] act_lo;
  logic              act_en;

  dpr_cfg_bank #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_cfg (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_base_in(cfg_base_in), .cfg_size_in(cfg_size_in),
    .cfg_commit(cfg_commit),
    .act_base(act_base), .act_lo(act_lo), .act_en(act_en));

  dpr_req_decode #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_dec (
    .clk(clk), .rst(rst),
    .act_base(act_base), .act_lo(act_lo), .act_en(act_en),
    .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
    .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_kind(rsp_kind),
    .rsp_tag(rsp_tag), .rsp_dram(rsp_dram), .rsp_fault(rsp_fault),
    .rsp_vga(rsp_vga));

  // R6: a fault always lies below the active base
  assert_fault_below_base_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr >= act_base) |=> !(rsp_fault || rsp_dram));

endmodule

// File: tb/test_dpr_checker.sv
`timescale 1ns/1ps
module test_dpr_checker;
  localparam int ADDR_W = 36;
  localparam int SIZE_W = 12;
  localparam int TAG_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0, cfg_commit = 1'b0, req_valid = 1'b0;
  logic [ADDR_W-1:0] cfg_base_in = '0, req_addr = '0;
  logic [SIZE_W-1:0] cfg_size_in = '0;
  logic [1:0] req_kind = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic rsp_valid, rsp_dram, rsp_fault, rsp_vga;
  logic [ADDR_W-1:0] rsp_addr;
  logic [1:0] rsp_kind;
  logic [TAG_W-1:0] rsp_tag;

  always #2 clk = ~clk;

  dpr_checker #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .TAG_W(TAG_W)) i_dpr_checker (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_base_in(cfg_base_in),
    .cfg_size_in(cfg_size_in), .cfg_commit(cfg_commit),
    .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
    .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_kind(rsp_kind), .rsp_tag(rsp_tag), .rsp_dram(rsp_dram),
    .rsp_fault(rsp_fault), .rsp_vga(rsp_vga));

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [1:0]        kind;
    logic [TAG_W-1:0]  tag;
    logic              dram;
    logic              fault;
    logic              vga;
  } exp_t;

  exp_t  exp_q[$];
  string rq_q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model of the configuration
  logic [ADDR_W-1:0] m_sh_base = '0, m_act_base = '0;
  logic [SIZE_W-1:0] m_sh_size = '0, m_act_size = '0;

  function automatic exp_t model(input logic [ADDR_W-1:0] a, input logic [1:0] k,
                                 input logic [TAG_W-1:0] t);
    exp_t e;
    logic [63:0] span, lo, base;
    logic hole, chk;
    base = 64'(m_act_base);
    span = 64'(m_act_size) << 20;
    lo   = (span >= base) ? 64'd0 : base - span;
    hole = (a >= 36'hA0000) && (a <= 36'hBFFFF);
    chk  = (k != 2'd0);
    e.addr = a; e.kind = k; e.tag = t; e.vga = hole;
    e.fault = chk && (m_act_size != 0) && (64'(a) >= lo) && (64'(a) < base);
    e.dram  = chk && (64'(a) < lo) && !hole;
    return e;
  endfunction

  task automatic fail_line(input string rq, input string what, input longint act, input longint exp);
    n_fail++;
    $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
  endtask

  // one cycle of stimulus, driven at the falling edge
  task automatic cyc(input bit v, input logic [ADDR_W-1:0] a, input logic [1:0] k,
                     input string rq, input bit wr = 0, input logic [ADDR_W-1:0] b = '0,
                     input logic [SIZE_W-1:0] s = '0, input bit cm = 0);
    @(negedge clk);
    req_valid = v; req_addr = a; req_kind = k; req_tag = req_tag + 1'b1;
    cfg_wr = wr; cfg_base_in = b; cfg_size_in = s; cfg_commit = cm;
    if (v) begin
      exp_q.push_back(model(a, k, req_tag));
      rq_q.push_back(rq);
    end
    if (cm) begin m_act_base = m_sh_base; m_act_size = m_sh_size; end
    if (wr) begin m_sh_base = b; m_sh_size = s; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 2'd0, "");
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rsp_valid) begin
        exp_t e; string rq;
        n_run++;
        if (exp_q.size() == 0) fail_line("R1", "unexpected rsp_valid", 1, 0);
        else begin
          e = exp_q.pop_front(); rq = rq_q.pop_front();
          if (rsp_addr != e.addr || rsp_kind != e.kind || rsp_tag != e.tag)
            fail_line({rq, "/R1"}, "payload", longint'({rsp_addr, rsp_tag}), longint'({e.addr, e.tag}));
          else if ({rsp_dram, rsp_fault, rsp_vga} != {e.dram, e.fault, e.vga})
            fail_line(rq, "dram/fault/vga", longint'({rsp_dram, rsp_fault, rsp_vga}),
                      longint'({e.dram, e.fault, e.vga}));
        end
      end else if (rsp_dram || rsp_fault || rsp_vga) begin
        n_run++;
        fail_line("R1", "flags without valid", longint'({rsp_dram, rsp_fault, rsp_vga}), 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  localparam logic [ADDR_W-1:0] B = 36'h0_8000_0000;

  initial begin
    repeat (3) @(negedge clk);
    n_run++;
    if (rsp_valid !== 1'b0) fail_line("R11", "rsp_valid in reset", longint'(rsp_valid), 0);
    @(negedge clk); rst = 0;
    // R11: reset config, nothing routed or faulted
    cyc(1, 36'h1000, 2'd1, "R11");
    cyc(1, 36'h0_7FC0_0000, 2'd2, "R11");
    // R9: shadow write only
    cyc(0, '0, 2'd0, "", 1, B, 12'd4);
    cyc(1, 36'h0_7FC0_0000, 2'd1, "R9");
    cyc(1, 36'h0_0000_1000, 2'd1, "R9");
    // R10: commit with same-edge request uses old, next uses new
    cyc(1, 36'h0_7FC0_0000, 2'd1, "R10", 0, '0, '0, 1);
    cyc(1, 36'h0_7FC0_0000, 2'd1, "R10");
    // R3 / R4 / R6 / R2
    cyc(1, 36'h0_7FBF_FFFF, 2'd1, "R4");
    cyc(1, 36'h0_7FFF_FFFF, 2'd2, "R3");
    cyc(1, B, 2'd1, "R6");
    cyc(1, 36'h8_0000_0000, 2'd3, "R6");
    cyc(1, 36'h0_7FC0_0000, 2'd0, "R2");
    cyc(1, 36'h0_1000_0000, 2'd0, "R2");
    cyc(1, 36'h0_7FD0_0000, 2'd3, "R2");
    // R5 video hole edges
    cyc(1, 36'hA0000, 2'd1, "R5");
    cyc(1, 36'hBFFFF, 2'd2, "R5");
    cyc(1, 36'hA0000, 2'd0, "R5");
    cyc(1, 36'hC0000, 2'd1, "R4");
    cyc(1, 36'h9FFFF, 2'd1, "R4");
    // R7: size zero
    cyc(0, '0, 2'd0, "", 1, B, 12'd0);
    cyc(0, '0, 2'd0, "", 0, '0, '0, 1);
    cyc(1, 36'h0_7FFF_FFFF, 2'd1, "R7");
    cyc(1, B, 2'd1, "R7");
    // R8: window wider than base clamps at zero
    cyc(0, '0, 2'd0, "", 1, 36'h10_0000, 12'd2);
    cyc(0, '0, 2'd0, "", 0, '0, '0, 1);
    cyc(1, 36'h0, 2'd1, "R8");
    cyc(1, 36'hA0000, 2'd2, "R8");
    cyc(1, 36'hF_FFFF, 2'd1, "R8");
    // R10: live growth mid-stream, write and commit on the same edge
    cyc(0, '0, 2'd0, "", 1, B, 12'd4);
    cyc(1, 36'h0_7F80_0000, 2'd1, "R10", 1, B, 12'd8, 1);
    cyc(1, 36'h0_7F80_0000, 2'd1, "R10", 0, '0, '0, 1);
    cyc(1, 36'h0_7F80_0000, 2'd1, "R10");
    cyc(1, 36'h0_7FBF_FFFF, 2'd2, "R10");
    // live shrink back with traffic every cycle
    cyc(1, 36'h0_7FA0_0000, 2'd1, "R10", 1, B, 12'd1);
    cyc(1, 36'h0_7FA0_0000, 2'd1, "R10", 0, '0, '0, 1);
    cyc(1, 36'h0_7FA0_0000, 2'd1, "R10");
    cyc(1, 36'h0_7FF0_0000, 2'd1, "R3");
    idle(3);
    n_run++;
    if (exp_q.size() != 0) fail_line("R1", "missing responses", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule